// File: doc/BRIEF.md
# Serial Audio Transmitter with Half-Drain Interrupt

This block sends audio samples out as a three-wire serial stream: a bit clock, a channel-select line (low for the left slot, high for the right slot) and a data line. A host loads 32-bit samples into a 32-word (128-byte) buffer. At each slot boundary the block moves one whole sample into a shift register and sends it most significant bit first, one bit per bit-clock period. Software is expected to load the buffer 16 words (64 bytes) at a time. A one-cycle interrupt pulse tells the host each time a 16-word half of the buffer has been drained, and a level flag shows when the buffer is empty.

Two enables control the block. `cnt_en` runs the clock generator. This is a clock divider that makes the bit clock, followed by a bit counter that makes the channel select. `tx_en` gates the data path. Clearing `tx_en` stops output at once and throws away everything that is queued. The clock generator keeps running as long as `cnt_en` stays high, so the link keeps its framing between bursts. In stereo mode each buffered word fills one slot. In mono mode each word is sent in both slots of one frame.

Top module: `i2s_half_tx`

## Requirements
- R1: The buffer holds 32 words of 32 bits. A write while 32 words are held is dropped and sets the sticky `overflow` flag. Clearing `tx_en` clears `overflow`.
- R2: After reset `fifo_empty`=1, `overflow`=0, `half_irq`=0, `sd`=0 and `ws`=0. `fifo_empty` is high exactly when no word is buffered.
- R3: In stereo mode (`mono`=0), raising `cnt_en` and `tx_en` together sends the buffered words in write order, one word per 32-bit slot, MSB first. The first word goes in a left slot (`ws`=0) and the slots then alternate left and right.
- R4: In mono mode (`mono`=1), each word is sent in the left slot and then again in the right slot of the same frame.
- R5: When a slot needs a word and the buffer is empty, that slot carries all zeros.
- R6: `half_irq` pulses for one cycle, in the cycle after the word in buffer position 16 or position 32 (counted from the last flush) is taken for sending.
- R7: Clearing `tx_en` forces `sd` low from the next cycle and empties the buffer in the same step, so queued words are never sent. Setting `tx_en` again with no new writes sends only zeros.
- R8: With `cnt_en`=1, `sck` and `ws` keep toggling whatever the value of `tx_en`. With `cnt_en`=0, `ws` rests low. `sck` then rests low when `launch_fall`=0 and high when `launch_fall`=1.
- R9: Each `sck` level lasts HALF_DIV clock cycles. `sd` and `ws` change only on the launch edge of `sck`, which is rising when `launch_fall`=0 and falling when `launch_fall`=1. `ws` holds steady for the 32 bits of each slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Data path enable; its falling edge flushes the buffer |
| cnt_en | input | 1 | Runs the bit clock and channel-select generator |
| mono | input | 1 | 1: each word fills both slots of a frame |
| launch_fall | input | 1 | 1: data launched on falling `sck`, `sck` idles high |
| wr_valid | input | 1 | Write strobe into the buffer |
| wr_data | input | 32 | Sample word to buffer |
| fifo_empty | output | 1 | Buffer holds no word |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| half_irq | output | 1 | One-cycle pulse when a 16-word half has drained |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select: 0 for the left slot, 1 for the right slot |
| sd | output | 1 | Serial data |

## Verification
`fifo_empty` and `overflow` react to a write or a flush one clock later. `half_irq` appears in the cycle after the pop edge. `sd` goes low one cycle after `tx_en` falls. Serial data appear on the first launch edge, HALF_DIV cycles after both enables rise. The bench drives inputs on falling clock edges and reads status on the next falling edge, after the register stage has settled. The serial stream is sampled at every `sck` capture edge, also on falling clock edges, and rebuilt into slots before being compared with the words the bench wrote. A timing monitor measures every `sck` half-period and flags any change of `sd` or `ws` away from a launch edge.

// File: rtl/i2s_half_pkg.sv
package i2s_half_pkg;
   // Strobes from the clock generator to the shifter, valid for one clock
   typedef struct packed {
      logic launch;      // next bit goes out at this edge
      logic slot_start;  // launch that opens a 32-bit slot
      logic right;       // slot being opened is the right channel
   } bit_evt_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/i2s_half_fifo.sv
module i2s_half_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              pop,
   output logic [WORD_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic              overflow,
   output logic              half_irq
);
   localparam int AW   = $clog2(DEPTH);
   localparam int HALF = DEPTH / 2;

   if (!i2s_half_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("i2s_half_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW:0]       wr_ptr, rd_ptr, count;
   logic              do_wr, do_pop, at_half;

   assign count   = wr_ptr - rd_ptr;
   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign do_wr   = wr_en && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rd_data = mem[rd_ptr[AW-1:0]];
   assign at_half = (rd_ptr[AW-1:0] == AW'(HALF - 1)) ||
                    (rd_ptr[AW-1:0] == AW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         overflow <= 1'b0;
         half_irq <= 1'b0;
      end else begin
         if (do_wr)              wr_ptr   <= wr_ptr + 1'b1;
         if (do_pop)             rd_ptr   <= rd_ptr + 1'b1;
         if (wr_en && full)      overflow <= 1'b1;
         half_irq <= do_pop && at_half;
      end
   end

   assert_full_write_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !flush) |=> (overflow && $stable(wr_ptr)));
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH));
   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !overflow));
   assert_irq_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      half_irq |-> $past(pop && !empty));
endmodule

// File: rtl/i2s_half_clkgen.sv
module i2s_half_clkgen
   import i2s_half_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int HALF_DIV  = 2,
   parameter int SLOT_BITS = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     launch_fall,
   output logic     sck,
   output logic     ws,
   output bit_evt_t evt
);
   localparam int IDX_W = $clog2(2 * SLOT_BITS);

   if (HALF_DIV < 1 || HALF_DIV > (1 << DIV_W)) begin : g_bad_div
      $error("i2s_half_clkgen: HALF_DIV must fit the divider counter");
   end
   if (!is_pow2(SLOT_BITS) || SLOT_BITS < 2) begin : g_bad_slot
      $error("i2s_half_clkgen: SLOT_BITS must be a power of two");
   end

   logic [DIV_W-1:0] div_cnt;
   logic [IDX_W-1:0] bit_idx, idx_nxt;
   logic             tick, phase, started;

   assign tick = run && (div_cnt == DIV_W'(HALF_DIV - 1));

   always_comb begin
      idx_nxt        = started ? bit_idx + 1'b1 : '0;
      evt.launch     = tick && !phase;
      evt.slot_start = evt.launch && (idx_nxt[IDX_W-2:0] == '0);
      evt.right      = idx_nxt[IDX_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         div_cnt <= '0;
         phase   <= 1'b0;
         started <= 1'b0;
         bit_idx <= '0;
      end else begin
         div_cnt <= tick ? '0 : div_cnt + 1'b1;
         if (tick) phase <= ~phase;
         if (evt.launch) begin
            started <= 1'b1;
            bit_idx <= idx_nxt;
         end
      end
   end

   assign sck = launch_fall ? ~phase : phase;
   assign ws  = bit_idx[IDX_W-1];

   assert_ws_rests_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ws);
   assert_sck_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(phase));
endmodule

// File: rtl/i2s_half_shift.sv
module i2s_half_shift
   import i2s_half_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              mono,
   input  bit_evt_t          evt,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_data,
   output logic              pop,
   output logic              sd
);
   logic [WORD_W-1:0] shreg, held, fresh;

   // a fresh word is taken for every stereo slot, or for the left slot in mono
   assign pop   = tx_en && evt.slot_start && (!mono || !evt.right);
   assign fresh = fifo_empty ? '0 : fifo_data;

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_en) begin
         shreg <= '0;
         held  <= '0;
      end else if (evt.slot_start) begin
         if (pop) begin
            shreg <= fresh;
            held  <= fresh;
         end else begin
            shreg <= held;
         end
      end else if (evt.launch) begin
         shreg <= {shreg[WORD_W-2:0], 1'b0};
      end
   end

   assign sd = shreg[WORD_W-1];

   assert_sd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !sd);
endmodule

// File: rtl/i2s_half_tx.sv
module i2s_half_tx
   import i2s_half_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int FIFO_BYTES = 128,
   parameter int DIV_W      = 8,
   parameter int HALF_DIV   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              cnt_en,
   input  logic              mono,
   input  logic              launch_fall,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              fifo_empty,
   output logic              overflow,
   output logic              half_irq,
   output logic              sck,
   output logic              ws,
   output logic              sd
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int DEPTH      = FIFO_BYTES / WORD_BYTES;

   if (WORD_W % 8 != 0 || FIFO_BYTES % WORD_BYTES != 0) begin : g_bad_geom
      $error("i2s_half_tx: buffer must hold a whole number of byte-wide words");
   end

   bit_evt_t          evt;
   logic              tx_q, flush, pop, full;
   logic [WORD_W-1:0] head;

   always_ff @(posedge clk) begin
      if (!rst_n) tx_q <= 1'b0;
      else        tx_q <= tx_en;
   end
   assign flush = tx_q && !tx_en;

   i2s_half_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_valid), .wr_data(wr_data),
      .pop(pop), .rd_data(head),
      .empty(fifo_empty), .full(full),
      .overflow(overflow), .half_irq(half_irq)
   );

   i2s_half_clkgen #(.DIV_W(DIV_W), .HALF_DIV(HALF_DIV), .SLOT_BITS(WORD_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(cnt_en), .launch_fall(launch_fall),
      .sck(sck), .ws(ws), .evt(evt)
   );

   i2s_half_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mono(mono), .evt(evt),
      .fifo_empty(fifo_empty), .fifo_data(head), .pop(pop), .sd(sd)
   );
endmodule

// File: tb/tb_i2s_half_tx.sv
module tb_i2s_half_tx;
   localparam int HD = 2;
   localparam int WW = 32;
   localparam int DEPTH = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, cnt_en = 1'b0, mono = 1'b0, launch_fall = 1'b0;
   logic wr_valid = 1'b0;
   logic [WW-1:0] wr_data = '0;
   logic fifo_empty, overflow, half_irq, sck, ws, sd;

   always #4 clk = ~clk;

   i2s_half_tx #(.HALF_DIV(HD)) dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cnt_en(cnt_en), .mono(mono),
      .launch_fall(launch_fall), .wr_valid(wr_valid), .wr_data(wr_data),
      .fifo_empty(fifo_empty), .overflow(overflow), .half_irq(half_irq),
      .sck(sck), .ws(ws), .sd(sd)
   );

   int total = 0, bad = 0;
   logic [WW-1:0] wds [64];

   // stream monitor state
   logic mon_en = 1'b0, mon_clear = 1'b0;
   logic [WW-1:0] slots [256];
   logic slot_ws [256];
   int nslots = 0, bitcnt = 0, irq_cnt = 0, half_len = 0, timing_bad = 0;
   logic seen_edge = 1'b0, cur_ws = 1'b0;
   logic [WW-1:0] acc = '0;
   logic prev_sck = 1'b0, prev_sd = 1'b0, prev_ws = 1'b0;

   always @(negedge clk) begin
      if (mon_clear) begin
         nslots = 0; bitcnt = 0; irq_cnt = 0; half_len = 0;
         timing_bad = 0; seen_edge = 1'b0;
      end else begin
         if (half_irq) irq_cnt++;
         if (mon_en) begin
            if (sck !== prev_sck) begin
               if (seen_edge && half_len != HD) timing_bad++;
               seen_edge = 1'b1;
               half_len  = 1;
               if (sck == launch_fall) begin
                  // capture edge: data and select must not move here
                  if (sd !== prev_sd || ws !== prev_ws) timing_bad++;
                  acc = {acc[WW-2:0], sd};
                  if (bitcnt == 0) cur_ws = ws;
                  else if (ws !== cur_ws) timing_bad++;
                  bitcnt++;
                  if (bitcnt == WW) begin
                     if (nslots < 256) begin
                        slots[nslots]   = acc;
                        slot_ws[nslots] = cur_ws;
                        nslots++;
                     end
                     bitcnt = 0;
                  end
               end
            end else begin
               half_len++;
               if (sd !== prev_sd || ws !== prev_ws) timing_bad++;
            end
         end
      end
      prev_sck = sck; prev_sd = sd; prev_ws = ws;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic mon_reset();
      @(posedge clk); mon_clear = 1'b1;
      @(posedge clk); mon_clear = 1'b0;
      @(negedge clk);
   endtask

   task automatic put(input logic [WW-1:0] w);
      @(negedge clk); wr_valid = 1'b1; wr_data = w;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic fill(input int n);
      for (int i = 0; i < n; i++) begin
         wds[i] = $urandom;
         put(wds[i]);
      end
   endtask

   task automatic start_run(input bit m, input bit lf);
      @(negedge clk); mono = m; launch_fall = lf;
      mon_reset();
      chk(sck == lf, "R8", "idle sck level", 32'(sck), 32'(lf));
      @(negedge clk); cnt_en = 1'b1; tx_en = 1'b1; mon_en = 1'b1;
   endtask

   task automatic stop_run(input bit lf);
      @(negedge clk); tx_en = 1'b0; cnt_en = 1'b0; mon_en = 1'b0;
      @(negedge clk);
      chk(ws == 1'b0, "R8", "ws rest after stop", 32'(ws), 32'd0);
      chk(sck == lf, "R8", "sck rest after stop", 32'(sck), 32'(lf));
      chk(sd == 1'b0, "R7", "sd after stop", 32'(sd), 32'd0);
      chk(fifo_empty == 1'b1, "R7", "flushed after stop", 32'(fifo_empty), 32'd1);
   endtask

   // expected words and channel per slot from R3, R4, R5
   function automatic logic [WW-1:0] exp_slot(input int i, input int n, input bit m);
      int k = m ? i / 2 : i;
      return (k < n) ? wds[k] : '0;
   endfunction

   function automatic int exp_irqs(input int n);
      return ((n >= DEPTH / 2) ? 1 : 0) + ((n >= DEPTH) ? 1 : 0);
   endfunction

   task automatic stream_case(input int n, input bit m, input bit lf, input int extra);
      int need = (m ? 2 * n : n) + extra;
      fill(n);
      chk(fifo_empty == (n == 0), "R2", "empty flag after fill", 32'(fifo_empty), 32'(n == 0));
      start_run(m, lf);
      while (nslots < need) @(negedge clk);
      stop_run(lf);
      for (int i = 0; i < need; i++) begin
         chk(slots[i] == exp_slot(i, n, m), m ? "R4" : ((i < n) ? "R3" : "R5"),
             "slot word", slots[i], exp_slot(i, n, m));
         chk(slot_ws[i] == i[0], "R3", "slot channel", 32'(slot_ws[i]), 32'(i[0]));
      end
      chk(irq_cnt == exp_irqs(n), "R6", "half interrupts", 32'(irq_cnt), 32'(exp_irqs(n)));
      chk(timing_bad == 0, "R9", "bit timing violations", 32'(timing_bad), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fifo_empty == 1'b1, "R2", "reset empty", 32'(fifo_empty), 32'd1);
      chk(overflow == 1'b0, "R2", "reset overflow", 32'(overflow), 32'd0);
      chk(half_irq == 1'b0, "R2", "reset irq", 32'(half_irq), 32'd0);
      chk(sd == 1'b0 && ws == 1'b0, "R2", "reset sd/ws", {30'd0, sd, ws}, 32'd0);
      chk(sck == 1'b0, "R8", "reset sck idle", 32'(sck), 32'd0);

      // directed: full buffer, stereo, rising launch
      stream_case(DEPTH, 1'b0, 1'b0, 4);
      // directed: exactly one half, mono, falling launch
      stream_case(DEPTH / 2, 1'b1, 1'b1, 2);
      // random lengths and modes
      for (int r = 0; r < 4; r++) begin
         stream_case(1 + int'($urandom % DEPTH), 1'($urandom), 1'($urandom), 2);
      end

      // R1: write beyond capacity is dropped and flagged
      @(negedge clk); mono = 1'b0; launch_fall = 1'b0;
      fill(DEPTH + 1);
      @(negedge clk);
      chk(overflow == 1'b1, "R1", "overflow set", 32'(overflow), 32'd1);
      start_run(1'b0, 1'b0);
      while (nslots < DEPTH + 2) @(negedge clk);
      stop_run(1'b0);
      chk(slots[DEPTH - 1] == wds[DEPTH - 1], "R1", "last kept word", slots[DEPTH - 1], wds[DEPTH - 1]);
      chk(slots[DEPTH] == '0, "R1", "dropped word not sent", slots[DEPTH], 32'd0);
      chk(overflow == 1'b0, "R1", "overflow cleared by flush", 32'(overflow), 32'd0);

      // R7/R8: flush mid-stream with the clock generator left running
      fill(DEPTH);
      start_run(1'b0, 1'b0);
      while (nslots < 3) @(negedge clk);
      tx_en = 1'b0; mon_en = 1'b0;
      @(negedge clk);
      chk(sd == 1'b0, "R7", "sd low after disable", 32'(sd), 32'd0);
      chk(fifo_empty == 1'b1, "R7", "buffer flushed", 32'(fifo_empty), 32'd1);
      begin
         int sck_ch = 0, ws_ch = 0;
         logic ps = sck, pw = ws;
         repeat (4 * WW * HD + 8) begin
            @(negedge clk);
            if (sck !== ps) sck_ch++;
            if (ws !== pw) ws_ch++;
            ps = sck; pw = ws;
         end
         chk(sck_ch > 0, "R8", "sck runs with tx off", 32'(sck_ch), 32'd1);
         chk(ws_ch > 0, "R8", "ws runs with tx off", 32'(ws_ch), 32'd1);
      end
      tx_en = 1'b1;
      begin
         int ones = 0;
         repeat (6 * WW * HD) begin
            @(negedge clk);
            if (sd) ones++;
         end
         chk(ones == 0, "R7", "discarded data never sent", 32'(ones), 32'd0);
         chk(fifo_empty == 1'b1, "R7", "still empty after re-enable", 32'(fifo_empty), 32'd1);
      end
      stop_run(1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule